// File: doc/BRIEF.md
# In-Order Retirement Reorder Buffer

This block is the commit end of an out-of-order core. Micro-operations enter it in program order, up to three in a cycle. Each one takes a slot in a 40-entry circular buffer and records the architectural register it will update, if it updates one. Execution units later report each slot's result, in any order, together with a fault flag and a mispredict flag. Every cycle the buffer looks at its three oldest slots and commits the finished ones, oldest first, into an eight-register architectural file.

A slot commits only when three things hold. It has finished, every older slot has committed, and it carries neither a fault nor a mispredict. When the oldest uncommitted slot in the window has finished with a fault or mispredict, that slot is not committed. The older slots in the same cycle still commit. The whole buffer is then emptied, and a one-cycle flush pulse reports the index of the offending slot, so the front end can restart. Renaming and issue are outside this block. Execution units name a slot by the index that the allocation side reports.

Top module: `rob_inorder_retire`

## Requirements
- R1: After reset the occupancy is 0, the allocation index is 0, the flush output is low and all eight architectural registers read 0.
- R2: A group of N ops (N = 0..3, given on `alloc_num`) gets consecutive slot indices starting at `alloc_tail`, and `alloc_tail` then advances by N. Lane 0 is the oldest op of the group.
- R3: When `alloc_num` exceeds the number of free slots (40 minus occupancy), `alloc_stall` is high in that cycle and no slot of the group is allocated.
- R4: A writeback (`wb_valid`) stores the result and flags into slot `wb_idx` and marks that slot finished from the next cycle on.
- R5: A finished slot does not commit while any older slot is unfinished.
- R6: At most three slots commit per cycle. Commitment stops at the first slot in the window that cannot commit, even if younger slots have finished. `retire_cnt` gives the number committing in the current cycle.
- R7: A committing slot whose destination flag is set writes its result into the architectural register named by its 3-bit tag. A slot with the flag clear commits without writing.
- R8: When two slots committing in the same cycle name the same register, the younger slot's value remains.
- R9: A finished slot with `wb_fault` or `wb_mispred` set, reached in commit order, is not committed and its result is not written. At the next clock edge `flush` is high for exactly one cycle with `flush_idx` equal to that slot's index, the occupancy becomes 0 and `alloc_tail` becomes 0. Older slots that commit in the same cycle are still written.
- R10: An allocation presented in the cycle in which a flush is decided is dropped.
- R11: Slot indices wrap from 39 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_num | input | 2 | Number of ops entering this cycle (0..3) |
| alloc_has_dst | input | 3 | Per lane: op writes an architectural register |
| alloc_dst | input | 9 | Per lane 3-bit destination tag, lane 0 in bits 2:0 |
| alloc_stall | output | 1 | Group does not fit; nothing allocated |
| alloc_tail | output | 6 | Index given to lane 0 of the next group |
| wb_valid | input | 1 | Result report valid |
| wb_idx | input | 6 | Slot being completed |
| wb_data | input | 32 | Result value |
| wb_fault | input | 1 | Op raised an exception |
| wb_mispred | input | 1 | Op was a mispredicted branch |
| retire_cnt | output | 2 | Slots committing this cycle |
| flush | output | 1 | One-cycle flush pulse |
| flush_idx | output | 6 | Slot that caused the flush |
| occupancy | output | 6 | Slots in use |
| rrf_addr | input | 3 | Architectural register read address |
| rrf_data | output | 32 | Architectural register read data |

## Verification
The commit logic is tried with four completion orders. In the first, results arrive in reverse order, which separates a buffer that waits for the oldest slot from one that commits whatever has finished. In the second, a hole sits in the middle of the window, which shows whether commitment stops at the first unfinished slot. In the third, a full window of three has two writers of the same register and one op with no destination, which shows that the youngest value wins and that ops without a destination write nothing. Last, a fault and then a mispredict land behind a finished older slot, which shows that the older op commits, the faulted one is not written, and an allocation in the flush cycle is lost. A long run of allocations without results fills the buffer across the 39-to-0 wrap and probes the exact free-slot limit.

// File: rtl/rob_pkg.sv
// Shared types for the reorder buffer.
// Assumes: consumers only need the per-slot commit classification.
package rob_pkg;
    // Commit-relevant condition of one window slot
    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_BUSY  = 2'd1,
        SLOT_READY = 2'd2,
        SLOT_FAULT = 2'd3
    } slot_state_t;
endpackage

// File: rtl/rob_entries.sv
// Slot storage of the reorder buffer: destination info, result, finish and
// exception bits. Offers LANES read ports for the commit window.
// Assumes: a writeback never targets a slot allocated in the same cycle;
// allocation requests arriving here are already checked against free space.
module rob_entries #(
    parameter int DEPTH  = 40,
    parameter int LANES  = 3,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 3,
    parameter int PTR_W  = 6,
    parameter int NUM_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_go,
    input  logic [NUM_W-1:0]        alloc_n,
    input  logic [PTR_W-1:0]        alloc_base,
    input  logic [LANES-1:0]        alloc_has_dst,
    input  logic [TAG_W-1:0]        alloc_dst [LANES],
    input  logic                    wb_valid,
    input  logic [PTR_W-1:0]        wb_idx,
    input  logic [DATA_W-1:0]       wb_data,
    input  logic                    wb_exc,
    input  logic [PTR_W-1:0]        rd_idx [LANES],
    input  logic [LANES-1:0]        rd_live,
    output rob_pkg::slot_state_t    rd_state [LANES],
    output logic [LANES-1:0]        rd_has_dst,
    output logic [TAG_W-1:0]        rd_dst [LANES],
    output logic [DATA_W-1:0]       rd_data [LANES]
);
    import rob_pkg::*;

    logic [DEPTH-1:0]  done_q;
    logic [DEPTH-1:0]  exc_q;
    logic [DEPTH-1:0]  hdst_q;
    logic [TAG_W-1:0]  dst_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    // Modulo-DEPTH pointer addition
    function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p,
                                                  input logic [PTR_W-1:0] k);
        logic [PTR_W:0] s;
        s = {1'b0, p} + {1'b0, k};
        if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
        return s[PTR_W-1:0];
    endfunction

    // Status bits: cleared by allocation, set by writeback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= '0;
            exc_q  <= '0;
            hdst_q <= '0;
        end else begin
            if (wb_valid) begin
                done_q[wb_idx] <= 1'b1;
                exc_q[wb_idx]  <= wb_exc;
            end
            if (alloc_go) begin
                for (int l = 0; l < LANES; l++) begin
                    if (alloc_n > NUM_W'(l)) begin
                        done_q[wrap_add(alloc_base, PTR_W'(l))] <= 1'b0;
                        exc_q[wrap_add(alloc_base, PTR_W'(l))]  <= 1'b0;
                        hdst_q[wrap_add(alloc_base, PTR_W'(l))] <= alloc_has_dst[l];
                    end
                end
            end
        end
    end

    // Payload storage: destination tags and results, no reset needed
    always_ff @(posedge clk) begin
        if (wb_valid) data_q[wb_idx] <= wb_data;
        if (alloc_go) begin
            for (int l = 0; l < LANES; l++) begin
                if (alloc_n > NUM_W'(l)) dst_q[wrap_add(alloc_base, PTR_W'(l))] <= alloc_dst[l];
            end
        end
    end

    // Window read ports with per-slot commit classification
    for (genvar g = 0; g < LANES; g++) begin : g_rd
        always_comb begin
            if (!rd_live[g])             rd_state[g] = SLOT_EMPTY;
            else if (!done_q[rd_idx[g]]) rd_state[g] = SLOT_BUSY;
            else if (exc_q[rd_idx[g]])   rd_state[g] = SLOT_FAULT;
            else                         rd_state[g] = SLOT_READY;
        end
        assign rd_has_dst[g] = hdst_q[rd_idx[g]];
        assign rd_dst[g]     = dst_q[rd_idx[g]];
        assign rd_data[g]    = data_q[rd_idx[g]];
    end
endmodule

// File: rtl/rob_retire_sel.sv
// Commit selection over the oldest LANES slots: commits the ready prefix and
// reports a flush when the first non-committing slot finished with a fault.
// Assumes: lane 0 is the oldest slot; purely combinational.
module rob_retire_sel #(
    parameter int LANES = 3,
    parameter int NUM_W = 2
) (
    input  rob_pkg::slot_state_t state [LANES],
    output logic [LANES-1:0]     ret_mask,
    output logic [NUM_W-1:0]     ret_cnt,
    output logic                 flush_now,
    output logic [NUM_W-1:0]     flush_lane
);
    import rob_pkg::*;

    // Scan oldest to youngest, stop at the first slot that cannot commit
    always_comb begin
        logic open;
        open       = 1'b1;
        ret_mask   = '0;
        ret_cnt    = '0;
        flush_now  = 1'b0;
        flush_lane = '0;
        for (int i = 0; i < LANES; i++) begin
            if (open && state[i] == SLOT_READY) begin
                ret_mask[i] = 1'b1;
                ret_cnt     = ret_cnt + 1'b1;
            end else begin
                if (open && state[i] == SLOT_FAULT) begin
                    flush_now  = 1'b1;
                    flush_lane = NUM_W'(i);
                end
                open = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rob_arch_rf.sv
// Architectural register file written by committing slots, with one read port.
// Assumes: write lanes are ordered oldest first; the youngest write wins.
module rob_arch_rf #(
    parameter int NREG   = 8,
    parameter int LANES  = 3,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  we,
    input  logic [TAG_W-1:0]  waddr [LANES],
    input  logic [DATA_W-1:0] wdata [LANES],
    input  logic [TAG_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs_q [NREG];

    // Register update, later lanes override earlier ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) regs_q[r] <= '0;
        end else begin
            for (int l = 0; l < LANES; l++) begin
                if (we[l]) regs_q[waddr[l]] <= wdata[l];
            end
        end
    end

    assign rdata = regs_q[raddr];
endmodule

// File: rtl/rob_inorder_retire.sv
// Reorder buffer top: allocation with backpressure, out-of-order completion,
// in-order commit of up to LANES slots per cycle, and flush on fault.
// Assumes: execution units only complete slots that are currently allocated.
module rob_inorder_retire #(
    parameter int DEPTH  = 40,
    parameter int LANES  = 3,
    parameter int NREG   = 8,
    parameter int DATA_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int TAG_W = $clog2(NREG),
    localparam int NUM_W = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_W-1:0]       alloc_num,
    input  logic [LANES-1:0]       alloc_has_dst,
    input  logic [LANES*TAG_W-1:0] alloc_dst,
    output logic                   alloc_stall,
    output logic [PTR_W-1:0]       alloc_tail,
    input  logic                   wb_valid,
    input  logic [PTR_W-1:0]       wb_idx,
    input  logic [DATA_W-1:0]      wb_data,
    input  logic                   wb_fault,
    input  logic                   wb_mispred,
    output logic [NUM_W-1:0]       retire_cnt,
    output logic                   flush,
    output logic [PTR_W-1:0]       flush_idx,
    output logic [CNT_W-1:0]       occupancy,
    input  logic [TAG_W-1:0]       rrf_addr,
    output logic [DATA_W-1:0]      rrf_data
);
    import rob_pkg::*;

    logic [PTR_W-1:0]  head_q, tail_q, fidx_q;
    logic [CNT_W-1:0]  count_q, free_slots;
    logic              flush_q, alloc_go, flush_now;
    logic [PTR_W-1:0]  win_idx [LANES];
    logic [LANES-1:0]  win_live, win_has_dst, ret_mask;
    logic [TAG_W-1:0]  win_dst [LANES];
    logic [TAG_W-1:0]  lane_dst [LANES];
    logic [DATA_W-1:0] win_data [LANES];
    slot_state_t       win_state [LANES];
    logic [NUM_W-1:0]  ret_cnt, flush_lane, alloc_eff;

    // Modulo-DEPTH pointer addition
    function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] p,
                                                  input logic [PTR_W-1:0] k);
        logic [PTR_W:0] s;
        s = {1'b0, p} + {1'b0, k};
        if (s >= (PTR_W+1)'(DEPTH)) s = s - (PTR_W+1)'(DEPTH);
        return s[PTR_W-1:0];
    endfunction

    // Free space check and allocation decision
    assign free_slots  = CNT_W'(DEPTH) - count_q;
    assign alloc_stall = CNT_W'(alloc_num) > free_slots;
    assign alloc_go    = (alloc_num != '0) && !alloc_stall && !flush_now;
    assign alloc_eff   = alloc_go ? alloc_num : '0;

    // Commit window indices and per-lane destination unpacking
    for (genvar g = 0; g < LANES; g++) begin : g_win
        assign win_idx[g]  = wrap_add(head_q, PTR_W'(g));
        assign win_live[g] = count_q > CNT_W'(g);
        assign lane_dst[g] = alloc_dst[g*TAG_W +: TAG_W];
    end

    rob_entries #(
        .DEPTH(DEPTH), .LANES(LANES), .DATA_W(DATA_W),
        .TAG_W(TAG_W), .PTR_W(PTR_W), .NUM_W(NUM_W)
    ) i_entries (
        .clk(clk), .rst_n(rst_n),
        .alloc_go(alloc_go), .alloc_n(alloc_num), .alloc_base(tail_q),
        .alloc_has_dst(alloc_has_dst), .alloc_dst(lane_dst),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
        .wb_exc(wb_fault | wb_mispred),
        .rd_idx(win_idx), .rd_live(win_live), .rd_state(win_state),
        .rd_has_dst(win_has_dst), .rd_dst(win_dst), .rd_data(win_data)
    );

    rob_retire_sel #(.LANES(LANES), .NUM_W(NUM_W)) i_sel (
        .state(win_state), .ret_mask(ret_mask), .ret_cnt(ret_cnt),
        .flush_now(flush_now), .flush_lane(flush_lane)
    );

    rob_arch_rf #(
        .NREG(NREG), .LANES(LANES), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) i_rrf (
        .clk(clk), .rst_n(rst_n),
        .we(ret_mask & win_has_dst), .waddr(win_dst), .wdata(win_data),
        .raddr(rrf_addr), .rdata(rrf_data)
    );

    // Head, tail, occupancy and flush report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
            flush_q <= 1'b0;
            fidx_q  <= '0;
        end else begin
            flush_q <= flush_now;
            if (flush_now) begin
                head_q  <= '0;
                tail_q  <= '0;
                count_q <= '0;
                fidx_q  <= win_idx[flush_lane];
            end else begin
                head_q  <= wrap_add(head_q, PTR_W'(ret_cnt));
                tail_q  <= wrap_add(tail_q, PTR_W'(alloc_eff));
                count_q <= count_q + CNT_W'(alloc_eff) - CNT_W'(ret_cnt);
            end
        end
    end

    assign alloc_tail = tail_q;
    assign retire_cnt = ret_cnt;
    assign flush      = flush_q;
    assign flush_idx  = fidx_q;
    assign occupancy  = count_q;
endmodule

// File: rtl/rob_inorder_retire_chk.sv
// Property checker for the reorder buffer, attached through bind.
// Assumes: parameters match the bound instance.
module rob_inorder_retire_chk #(
    parameter int DEPTH = 40,
    parameter int PTR_W = 6,
    parameter int CNT_W = 6,
    parameter int NUM_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_stall,
    input logic [PTR_W-1:0] alloc_tail,
    input logic [NUM_W-1:0] retire_cnt,
    input logic             flush,
    input logic [CNT_W-1:0] occupancy
);
    // R3: a stalled group never raises occupancy
    a_r3_stall_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_stall |=> occupancy <= $past(occupancy));

    // R3: occupancy never exceeds the buffer size
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(DEPTH));

    // R6: commits are bounded by what is held
    a_r6_retire_within_occ: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(retire_cnt) <= occupancy);

    // R9: flush is a single-cycle pulse
    a_r9_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush);

    // R9: a flush leaves the buffer empty with the index back at zero
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (occupancy == '0 && alloc_tail == '0));

    // R11: the allocation index stays within the buffer
    a_r11_tail_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_tail < PTR_W'(DEPTH));
endmodule

bind rob_inorder_retire rob_inorder_retire_chk #(
    .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W), .NUM_W(NUM_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .alloc_stall(alloc_stall),
    .alloc_tail(alloc_tail), .retire_cnt(retire_cnt),
    .flush(flush), .occupancy(occupancy)
);

// File: tb/test_rob_inorder_retire.sv
module test_rob_inorder_retire;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  alloc_num = '0;
    logic [2:0]  alloc_has_dst = '0;
    logic [8:0]  alloc_dst = '0;
    logic        alloc_stall;
    logic [5:0]  alloc_tail;
    logic        wb_valid = 1'b0;
    logic [5:0]  wb_idx = '0;
    logic [31:0] wb_data = '0;
    logic        wb_fault = 1'b0;
    logic        wb_mispred = 1'b0;
    logic [1:0]  retire_cnt;
    logic        flush;
    logic [5:0]  flush_idx;
    logic [5:0]  occupancy;
    logic [2:0]  rrf_addr = '0;
    logic [31:0] rrf_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rob_inorder_retire i_rob_inorder_retire (
        .clk(clk), .rst_n(rst_n),
        .alloc_num(alloc_num), .alloc_has_dst(alloc_has_dst), .alloc_dst(alloc_dst),
        .alloc_stall(alloc_stall), .alloc_tail(alloc_tail),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
        .wb_fault(wb_fault), .wb_mispred(wb_mispred),
        .retire_cnt(retire_cnt), .flush(flush), .flush_idx(flush_idx),
        .occupancy(occupancy), .rrf_addr(rrf_addr), .rrf_data(rrf_data)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_alloc(input int n, input logic [2:0] h,
                             input int d0, input int d1, input int d2);
        alloc_num     = 2'(n);
        alloc_has_dst = h;
        alloc_dst     = {3'(d2), 3'(d1), 3'(d0)};
    endtask

    task automatic clear_inputs();
        alloc_num = '0; alloc_has_dst = '0; alloc_dst = '0;
        wb_valid = 1'b0; wb_fault = 1'b0; wb_mispred = 1'b0;
    endtask

    task automatic do_wb(input int idx, input logic [31:0] d, input bit f, input bit m);
        wb_valid = 1'b1; wb_idx = 6'(idx); wb_data = d; wb_fault = f; wb_mispred = m;
        step();
        clear_inputs();
    endtask

    task automatic check_reg(input string req, input int r, input logic [31:0] exp);
        rrf_addr = 3'(r);
        #1;
        check(req, $sformatf("reg%0d", r), rrf_data, exp);
    endtask

    task automatic t_reset();
        check("R1", "occupancy", occupancy, 0);
        check("R1", "tail", alloc_tail, 0);
        check("R1", "flush", flush, 0);
        for (int r = 0; r < 8; r++) check_reg("R1", r, 32'h0);
    endtask

    // Reverse-order completion: nothing commits until the oldest finishes
    task automatic t_in_order();
        set_alloc(3, 3'b111, 1, 2, 3);
        step(); clear_inputs();
        check("R2", "occupancy after group", occupancy, 3);
        check("R2", "tail after group", alloc_tail, 3);
        do_wb(2, 32'hA2, 0, 0);
        do_wb(1, 32'hB1, 0, 0);
        check("R5", "no commit past unfinished head", retire_cnt, 0);
        check("R5", "occupancy held", occupancy, 3);
        check_reg("R5", 2, 32'h0);
        do_wb(0, 32'hC0, 0, 0);
        check("R6", "three commit together", retire_cnt, 3);
        step();
        check("R4", "buffer drained", occupancy, 0);
        check_reg("R7", 1, 32'hC0);
        check_reg("R7", 2, 32'hB1);
        check_reg("R4", 3, 32'hA2);
    endtask

    // Hole in the middle: commit stops at the first unfinished slot
    task automatic t_gap();
        set_alloc(3, 3'b111, 4, 5, 6);
        step(); clear_inputs();
        do_wb(3, 32'h33, 0, 0);
        do_wb(5, 32'h55, 0, 0);
        check("R6", "head committed, gap blocks", occupancy, 2);
        check("R6", "no commit past gap", retire_cnt, 0);
        check_reg("R6", 6, 32'h0);
        do_wb(4, 32'h44, 0, 0);
        check("R6", "two commit after gap fills", retire_cnt, 2);
        step();
        check("R6", "empty", occupancy, 0);
        check_reg("R7", 4, 32'h33);
        check_reg("R7", 5, 32'h44);
        check_reg("R7", 6, 32'h55);
    endtask

    // Same destination twice and one op with no destination in one window
    task automatic t_same_dest();
        set_alloc(3, 3'b011, 7, 7, 0);
        step(); clear_inputs();
        do_wb(8, 32'h88, 0, 0);
        do_wb(7, 32'h77, 0, 0);
        do_wb(6, 32'h66, 0, 0);
        check("R6", "full window commits", retire_cnt, 3);
        step();
        check_reg("R8", 7, 32'h77);
        check_reg("R7", 0, 32'h0);
    endtask

    // Fill past the wrap point and probe the free-slot limit
    task automatic t_backpressure();
        for (int b = 0; b < 13; b++) begin
            set_alloc(3, 3'b111, 1, 2, 3);
            step();
        end
        clear_inputs();
        check("R3", "occupancy 39", occupancy, 39);
        check("R11", "tail wrapped", alloc_tail, 8);
        set_alloc(2, 3'b011, 1, 2, 0);
        #1;
        check("R3", "stall on 2 with 1 free", alloc_stall, 1);
        step();
        check("R3", "nothing allocated", occupancy, 39);
        check("R3", "tail held", alloc_tail, 8);
        set_alloc(1, 3'b001, 1, 0, 0);
        #1;
        check("R3", "no stall on exact fit", alloc_stall, 0);
        step(); clear_inputs();
        check("R3", "full", occupancy, 40);
        check("R2", "tail after fill", alloc_tail, 9);
    endtask

    // Fault behind a finished older slot
    task automatic t_fault();
        do_wb(10, 32'hDEAD, 1, 0);
        check("R9", "no commit before head done", retire_cnt, 0);
        do_wb(9, 32'h9999, 0, 0);
        check("R9", "older slot commits", retire_cnt, 1);
        step();
        check("R9", "flush raised", flush, 1);
        check("R9", "flush index", flush_idx, 10);
        check("R9", "occupancy cleared", occupancy, 0);
        check("R9", "tail cleared", alloc_tail, 0);
        check_reg("R9", 1, 32'h9999);
        check_reg("R9", 2, 32'hB1);
        step();
        check("R9", "flush single cycle", flush, 0);
    endtask

    // Mispredict at the head with an allocation in the flush cycle
    task automatic t_mispredict();
        set_alloc(1, 3'b001, 5, 0, 0);
        step(); clear_inputs();
        do_wb(0, 32'hBAD5, 0, 1);
        set_alloc(3, 3'b111, 1, 2, 3);
        #1;
        check("R9", "faulted slot not committed", retire_cnt, 0);
        step(); clear_inputs();
        check("R9", "flush on mispredict", flush, 1);
        check("R9", "mispredict index", flush_idx, 0);
        check("R10", "allocation dropped", occupancy, 0);
        check("R10", "tail stays zero", alloc_tail, 0);
        check_reg("R9", 5, 32'h44);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_in_order();
        t_gap();
        t_same_dest();
        t_backpressure();
        t_fault();
        t_mispredict();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule